// File: doc/BRIEF.md
# Spectral Power Integrator

This block sits behind an FFT core and builds an averaged power spectrum. Each incoming complex bin is turned into a power value (real part squared plus imaginary part squared) and added into a per-bin accumulation store. When a programmable number of complete frames has been folded in, the block streams the whole integrated spectrum out over a valid/ready interface, one 32-bit word per bin, flagging the final word.

A one-bit mode selects how much of each frame matters. With a single real input channel the upper half of the transform mirrors the lower half, so only the lower half of the bins is kept. With quadrature (I/Q) input every bin carries distinct information and all of them are kept. The frame length defaults to 4096 bins and is set by a parameter.

The first frame of every integration period writes the store directly rather than adding to it, so no clearing pass is needed between periods. While a finished spectrum is being drained, the store is busy: any frame that starts in that window is discarded and a sticky status flag reports the loss until the next period begins.

Top module: `spectral_power_integrator`

## Requirements
- R1: Each kept bin contributes re*re + im*im, with re and im taken as signed two's complement values of DW bits (default 16).
- R2: With in_mode = 0 only bins 0 to FRAME_BINS/2-1 are integrated and the readout holds exactly FRAME_BINS/2 words; upper bins have no effect on any word.
- R3: With in_mode = 1 all FRAME_BINS bins are integrated and the readout holds exactly FRAME_BINS words, in bin order starting at bin 0.
- R4: out_valid stays low until the programmed number of whole frames of the current period has been received.
- R5: in_mode and frame_count are captured on the first frame-start of a period and later changes have no effect until the next period; a frame_count of 0 behaves as 1.
- R6: The first frame of a period replaces the stored value of each kept bin, so nothing carries over from an earlier period.
- R7: An accumulated value that would exceed 32'hFFFFFFFF is held at 32'hFFFFFFFF.
- R8: While out_valid is high and out_ready low, out_valid and out_data stay unchanged; out_last is high only with the final word of the readout.
- R9: A frame whose start arrives while results are pending or being read out is discarded and sets frame_dropped, which stays high until the first frame-start of the next period.
- R10: After reset out_valid, out_last and frame_dropped are low.
- R11: Valid beats that arrive outside a frame (no frame-start seen yet for them) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input bin beat is present |
| in_sof | input | 1 | Beat is bin 0 of a frame |
| in_re | input | DW | Real part, signed |
| in_im | input | DW | Imaginary part, signed |
| in_mode | input | 1 | 0: single real channel, lower half kept; 1: quadrature, all bins kept |
| frame_count | input | CNT_W | Frames per integration period (0 acts as 1) |
| out_valid | output | 1 | Result word available |
| out_ready | input | 1 | Sink accepts the result word |
| out_data | output | 32 | Integrated power of the current bin |
| out_last | output | 1 | Final word of the spectrum |
| frame_dropped | output | 1 | A frame was discarded during readout |

## Verification
The bench targets the boundary between the kept lower half and the ignored upper half in single-channel mode, where a design ignoring the mode would emit too many words or mark the wrong word last. It changes mode and count right after a period starts, which a design that reads them live would follow into a stalled or misshaped readout, and runs successive periods back to back so that a missing overwrite on the first frame shows up as carried-over energy. Full-scale negative inputs over two frames push the sum past 32 bits, which a wrapping adder would report as zero, and a frame injected under backpressure must leave the held word, the counts and the next spectrum untouched while raising the drop flag.

// File: rtl/spi_pkg.sv
package spi_pkg;

    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_DRAIN   = 2'd1,
        ST_READ    = 2'd2
    } spi_state_e;

    localparam int unsigned WORD_W = 32;

endpackage

// File: rtl/spi_bin_power.sv
module spi_bin_power #(
    parameter int unsigned DW = 16,
    parameter int unsigned OW = 32
) (
    input  logic signed [DW-1:0] re_i,
    input  logic signed [DW-1:0] im_i,
    output logic [OW-1:0]        pwr_o
);
    localparam int unsigned SW = 2 * DW + 1;

    logic signed [2*DW-1:0] sq_re;
    logic signed [2*DW-1:0] sq_im;
    logic [SW-1:0]          sum;

    always_comb begin
        sq_re = re_i * re_i;
        sq_im = im_i * im_i;
        sum   = {1'b0, sq_re} + {1'b0, sq_im};
    end

    generate
        if (SW > OW) begin : g_clip
            assign pwr_o = (|sum[SW-1:OW]) ? '1 : sum[OW-1:0];
        end else begin : g_wide
            assign pwr_o = OW'(sum);
        end
    endgenerate

endmodule

// File: rtl/spi_acc_mem.sv
module spi_acc_mem #(
    parameter int unsigned AW = 12,
    parameter int unsigned OW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_first,
    input  logic [OW-1:0] wr_pwr,
    input  logic [AW-1:0] rd_addr,
    output logic [OW-1:0] rd_data
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [OW-1:0] store [DEPTH];
    logic [OW-1:0] old_val;
    logic [OW:0]   wide_sum;
    logic [OW-1:0] new_val;

    always_comb begin
        old_val  = store[wr_addr];
        wide_sum = {1'b0, old_val} + {1'b0, wr_pwr};
        if (wr_first)
            new_val = wr_pwr;
        else
            new_val = wide_sum[OW] ? '1 : wide_sum[OW-1:0];
    end

    always_ff @(posedge clk) begin
        if (wr_en)
            store[wr_addr] <= new_val;
    end

    assign rd_data = store[rd_addr];

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_first) |-> (new_val >= old_val && new_val >= wr_pwr));

endmodule

// File: rtl/spectral_power_integrator.sv
module spectral_power_integrator
    import spi_pkg::*;
#(
    parameter int unsigned LOG2_BINS = 12,
    parameter int unsigned DW        = 16,
    parameter int unsigned CNT_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_sof,
    input  logic signed [DW-1:0] in_re,
    input  logic signed [DW-1:0] in_im,
    input  logic                 in_mode,
    input  logic [CNT_W-1:0]     frame_count,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [WORD_W-1:0]    out_data,
    output logic                 out_last,
    output logic                 frame_dropped
);
    localparam int unsigned AW         = LOG2_BINS;
    localparam int unsigned FRAME_BINS = 1 << LOG2_BINS;
    localparam logic [AW-1:0] HALF_IDX = AW'(FRAME_BINS / 2);

    typedef struct packed {
        spi_state_e        st;
        logic              in_frame;
        logic [AW-1:0]     bin;
        logic [CNT_W-1:0]  frames;
        logic [CNT_W-1:0]  target;
        logic              quad;
        logic [AW-1:0]     rd;
        logic              dropped;
        logic              s1_vld;
        logic [AW-1:0]     s1_addr;
        logic              s1_first;
        logic [WORD_W-1:0] s1_pwr;
    } ctl_t;

    ctl_t q, d;

    logic [WORD_W-1:0] beat_pwr;
    logic [WORD_W-1:0] rd_word;
    logic              new_period;
    logic              beat_ok;
    logic [AW-1:0]     addr;
    logic              eff_quad;
    logic [CNT_W-1:0]  eff_target;
    logic              keep;
    logic [AW-1:0]     last_idx;
    logic [CNT_W-1:0]  frames_inc;

    spi_bin_power #(.DW(DW), .OW(WORD_W)) u_power (
        .re_i  (in_re),
        .im_i  (in_im),
        .pwr_o (beat_pwr)
    );

    spi_acc_mem #(.AW(AW), .OW(WORD_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (q.s1_vld),
        .wr_addr  (q.s1_addr),
        .wr_first (q.s1_first),
        .wr_pwr   (q.s1_pwr),
        .rd_addr  (q.rd),
        .rd_data  (rd_word)
    );

    always_comb begin
        d          = q;
        d.s1_vld   = 1'b0;
        new_period = in_valid && in_sof && (q.frames == '0);
        beat_ok    = in_valid && (in_sof || q.in_frame);
        addr       = in_sof ? '0 : q.bin;
        eff_quad   = new_period ? in_mode : q.quad;
        if (new_period)
            eff_target = (frame_count == '0) ? CNT_W'(1) : frame_count;
        else
            eff_target = q.target;
        keep       = eff_quad || (addr < HALF_IDX);
        last_idx   = q.quad ? '1 : (HALF_IDX - AW'(1));
        frames_inc = q.frames + CNT_W'(1);

        unique case (q.st)
            ST_COLLECT: begin
                if (beat_ok) begin
                    if (new_period) begin
                        d.quad    = in_mode;
                        d.target  = eff_target;
                        d.dropped = 1'b0;
                    end
                    d.s1_vld   = keep;
                    d.s1_addr  = addr;
                    d.s1_first = (q.frames == '0);
                    d.s1_pwr   = beat_pwr;
                    if (addr == '1) begin
                        d.in_frame = 1'b0;
                        d.bin      = '0;
                        d.frames   = frames_inc;
                        if (frames_inc == eff_target)
                            d.st = ST_DRAIN;
                    end else begin
                        d.in_frame = 1'b1;
                        d.bin      = addr + AW'(1);
                    end
                end
            end
            ST_DRAIN: begin
                d.st = ST_READ;
                d.rd = '0;
                if (in_valid && in_sof)
                    d.dropped = 1'b1;
            end
            ST_READ: begin
                if (in_valid && in_sof)
                    d.dropped = 1'b1;
                if (out_ready) begin
                    if (q.rd == last_idx) begin
                        d.st     = ST_COLLECT;
                        d.frames = '0;
                        d.rd     = '0;
                    end else begin
                        d.rd = q.rd + AW'(1);
                    end
                end
            end
            default: d.st = ST_COLLECT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign out_valid     = (q.st == ST_READ);
    assign out_last      = out_valid && (q.rd == last_idx);
    assign out_data      = rd_word;
    assign frame_dropped = q.dropped;

    // R8
    hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R8
    last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R2
    half_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.s1_vld && !q.quad) |-> (q.s1_addr < HALF_IDX));

    // R9
    drop_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_dropped) |-> ($past(q.st) != ST_COLLECT));

    // R4
    no_write_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !q.s1_vld);

endmodule

// File: tb/spectral_power_integrator_tb.sv
module spectral_power_integrator_tb;
    localparam int LB    = 3;
    localparam int BINS  = 1 << LB;
    localparam int HALF  = BINS / 2;
    localparam int DW    = 16;
    localparam int CW    = 16;
    localparam int NV    = 6;

    localparam int V_MODE [NV] = '{1, 1, 0, 1, 0, 1};
    localparam int V_CNT  [NV] = '{1, 3, 2, 0, 1, 2};
    localparam int V_SEED [NV] = '{1, 2, 3, 4, 5, 99};

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic                 in_sof = 1'b0;
    logic signed [DW-1:0] in_re = '0;
    logic signed [DW-1:0] in_im = '0;
    logic                 in_mode = 1'b0;
    logic [CW-1:0]        frame_count = '0;
    logic                 out_valid;
    logic                 out_ready = 1'b0;
    logic [31:0]          out_data;
    logic                 out_last;
    logic                 frame_dropped;

    int     errors = 0;
    int     checks = 0;
    longint exp_pwr [BINS];

    always #4 clk = ~clk;

    spectral_power_integrator #(.LOG2_BINS(LB), .DW(DW), .CNT_W(CW)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_sof        (in_sof),
        .in_re         (in_re),
        .in_im         (in_im),
        .in_mode       (in_mode),
        .frame_count   (frame_count),
        .out_valid     (out_valid),
        .out_ready     (out_ready),
        .out_data      (out_data),
        .out_last      (out_last),
        .frame_dropped (frame_dropped)
    );

    function automatic string vec_req(int i);
        case (i)
            0: return "R1";
            1: return "R6";
            2: return "R2";
            3: return "R5";
            4: return "R11";
            default: return "R7";
        endcase
    endfunction

    function automatic int gen_re(int seed, int f, int b);
        if (seed == 99) return -32768;
        return ((seed * 37 + f * 11 + b * 53) % 4001) - 2000;
    endfunction

    function automatic int gen_im(int seed, int f, int b);
        if (seed == 99) return -32768;
        return ((seed * 13 + f * 7 + b * 29) % 3001) - 1500;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic stray_beats();
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = 1'b0;
            in_re = 16'sd30000; in_im = -16'sd30000;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_frame(int seed, int f, bit quad, bit acc, bit first);
        for (int b = 0; b < BINS; b++) begin
            int r;
            int m;
            @(negedge clk);
            if (first && b == 1) begin
                frame_count = 16'd13;
                in_mode     = ~quad;
            end
            r = gen_re(seed, f, b);
            m = gen_im(seed, f, b);
            if (!quad && b >= HALF) begin
                r = 30000; m = -29000;
            end
            in_valid = 1'b1;
            in_sof   = (b == 0);
            in_re    = 16'(r);
            in_im    = 16'(m);
            if (acc && (quad || b < HALF))
                exp_pwr[b] += longint'(r) * r + longint'(m) * m;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
    endtask

    task automatic readout(int n, string req, int stall, bit inject);
        int     k = 0;
        int     guard = 0;
        longint e;
        logic [31:0] held;
        out_ready = (stall == 0) && !inject;
        while (k < n && guard < 2000) begin
            @(negedge clk);
            guard++;
            if (out_valid) begin
                if (k == 0 && (stall > 0 || inject)) begin
                    held = out_data;
                    if (inject) begin
                        send_frame(50, 0, 1'b1, 1'b0, 1'b0);
                        check(frame_dropped == 1'b1, "R9", "drop flag set", frame_dropped, 1);
                    end else begin
                        repeat (stall) @(negedge clk);
                    end
                    check(out_valid == 1'b1, "R8", "valid held", out_valid, 1);
                    check(out_data == held, "R8", "data held", out_data, held);
                    out_ready = 1'b1;
                end
                e = (exp_pwr[k] > 64'hFFFFFFFF) ? 64'hFFFFFFFF : exp_pwr[k];
                check(longint'(out_data) == e, req, $sformatf("bin %0d power", k), out_data, e);
                check(out_last == (k == n - 1), "R8", $sformatf("last flag bin %0d", k), out_last, (k == n - 1));
                k++;
            end
        end
        check(k == n, (n == BINS) ? "R3" : "R2", "words seen", k, n);
        @(negedge clk);
        check(out_valid == 1'b0, (n == BINS) ? "R3" : "R2", "no extra word", out_valid, 0);
        out_ready = 1'b0;
    endtask

    task automatic run_period(int mode, int cnt, int seed, string req, int stall, bit inject);
        int eff;
        eff = (cnt == 0) ? 1 : cnt;
        for (int b = 0; b < BINS; b++) exp_pwr[b] = 0;
        in_mode     = mode[0];
        frame_count = CW'(cnt);
        // R11: beats without a frame start are ignored
        stray_beats();
        for (int f = 0; f < eff; f++) begin
            send_frame(seed, f, mode[0], 1'b1, f == 0);
            if (f < eff - 1)
                check(out_valid == 1'b0, "R4", "early release", out_valid, 0);
        end
        readout(mode[0] ? BINS : HALF, req, stall, inject);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10
        check(out_valid == 1'b0, "R10", "reset valid", out_valid, 0);
        check(out_last == 1'b0, "R10", "reset last", out_last, 0);
        check(frame_dropped == 1'b0, "R10", "reset drop flag", frame_dropped, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++)
            run_period(V_MODE[v], V_CNT[v], V_SEED[v], vec_req(v), (v == 1) ? 3 : 0, 1'b0);

        // R9: frame injected under backpressure is discarded
        run_period(1, 1, 7, "R9", 0, 1'b1);
        check(frame_dropped == 1'b1, "R9", "flag persists", frame_dropped, 1);
        run_period(1, 1, 8, "R9", 0, 1'b0);
        check(frame_dropped == 1'b0, "R9", "flag cleared", frame_dropped, 0);

        // R2: single-channel period after a quadrature one, with overwrite (R6)
        run_period(0, 1, 11, "R6", 0, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule